// File: doc/BRIEF.md
# Matrix Keypad Scanner with Wait-and-Recheck Debounce

The block walks a 64-key switch matrix, eight rows by eight columns, one position at a time. It presents a 6-bit position code on two 3-bit select buses. The upper three bits of the code drive the row select and the lower three drive the column select. External multiplexing hardware returns one active-low sense line, which reads low when the selected switch is closed. Each position is held for a programmable settle time before the sense line is sampled.

When a closed switch is found, the scan freezes on that position. The block then waits a debounce window and samples the same position again. A press that is still present is turned into an 8-bit character through a computed 64-entry map. The position code is the index into that map. The character and the code go out on a valid/ready stream. The scan stays frozen until the consumer takes the key. It then stays frozen until the switch has read open for one whole debounce window without a break. Only then does scanning continue, from the next position, so a held key is reported once.

Back-pressure rules: `key_valid` rises only after a press has been confirmed. Once it is high, it stays high, and `key_code` and `key_char` stay unchanged, until a cycle in which `key_ready` is high. That cycle is the transfer. Each confirmed press produces exactly one transfer. With `key_ready` tied high, the valid pulse lasts one cycle.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is held, the row select and column select are both 0 and `key_valid` is low.
- R2: While no key is closed, the 6-bit position code {row_sel, col_sel} holds for SETTLE_CYCLES clocks and then increments by one. It wraps from 63 to 0. The row select is code bits 5:3 and the column select is code bits 2:0.
- R3: If the sense line is low on the last settle cycle of a position, scanning stops and the selects stay on that position for DEBOUNCE_CYCLES clocks.
- R4: If the sense line is high on the last clock of that debounce window, no key is reported, and scanning resumes at the next position.
- R5: If the sense line is still low on the last clock of the window, `key_valid` rises with `key_code` equal to the held position.
- R6: The character map is as follows. Codes 0 to 9 give 0x30 to 0x39 ('0'-'9'). Codes 10 to 35 give 0x41 to 0x5A ('A'-'Z'). Codes 36 to 61 give 0x61 to 0x7A ('a'-'z'). Code 62 gives 0x2A ('*') and code 63 gives 0x23 ('#').
- R7: While `key_valid` is high and `key_ready` is low, `key_valid`, `key_code` and `key_char` hold. After a transfer, `key_valid` is low on the next clock.
- R8: After a transfer, the selects stay on the same position until the sense line has read high for DEBOUNCE_CYCLES consecutive clocks. Any low restarts that count. No further report is made while the key stays held. On the clock that completes the count, the code moves to the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_sel | output | ROW_W (3) | Row select, position code bits 5:3 |
| col_sel | output | COL_W (3) | Column select, position code bits 2:0 |
| sense_n | input | 1 | Selected switch state, low when closed |
| key_valid | output | 1 | Confirmed key offered on the stream |
| key_ready | input | 1 | Consumer accepts the offered key |
| key_code | output | 6 | Position code of the offered key |
| key_char | output | 8 | Character for the offered key |

## Verification
The case hardest to reach from the ports is a switch that opens again inside the recheck window. The sense line is low at the sampling instant but high when the window ends. The bench models the matrix as a combinational function of the select outputs. It watches for the selects to arrive on the chosen position and then releases the switch a few clocks later, inside the check window. A second hard case is a bounce after acceptance. It is produced by re-closing the switch part-way through the release window, which must push the resume point out by a full window.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_CHECK   = 2'd1,
    ST_OFFER   = 2'd2,
    ST_RELEASE = 2'd3
  } scan_state_t;

  // Character for a matrix position: digits, upper case, lower case, '*', '#'
  function automatic logic [7:0] code_to_char(input int idx);
    logic [7:0] ch;
    if (idx < 10)       ch = 8'(8'h30 + idx);
    else if (idx < 36)  ch = 8'(8'h41 + (idx - 10));
    else if (idx < 62)  ch = 8'(8'h61 + (idx - 36));
    else if (idx == 62) ch = 8'h2A;
    else                ch = 8'h23;
    return ch;
  endfunction

endpackage

// File: rtl/keyscan_stepper.sv
module keyscan_stepper #(
  parameter int CODE_W = 6,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              bump,
  output logic [CODE_W-1:0] code,
  output logic              settle_end
);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= '0;
    else if (bump) code_q <= code_q + 1'b1;
  end

  generate
    if (SETTLE_CYCLES <= 1) begin : g_no_dwell
      assign settle_end = run;
    end else begin : g_dwell
      localparam int DW = $clog2(SETTLE_CYCLES);
      logic [DW-1:0] dwell_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !run || bump) dwell_q <= '0;
        else                        dwell_q <= dwell_q + 1'b1;
      end
      assign settle_end = run && (dwell_q == DW'(SETTLE_CYCLES - 1));
    end
  endgenerate

  assign code = code_q;

endmodule

// File: rtl/keyscan_timer.sv
module keyscan_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)       cnt_q <= '0;
    else if (en && !done)    cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LAST);

endmodule

// File: rtl/keyscan_charmap.sv
module keyscan_charmap #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] idx,
  output logic [7:0]        ch
);

  localparam int N = 1 << CODE_W;

  logic [7:0] table_w [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_entry
      assign table_w[i] = keyscan_pkg::code_to_char(i);
    end
  endgenerate

  assign ch = table_w[idx];

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int SETTLE_CYCLES = 4,
  parameter int DEBOUNCE_CYCLES = 500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [ROW_W-1:0]       row_sel,
  output logic [COL_W-1:0]       col_sel,
  input  logic                   sense_n,
  output logic                   key_valid,
  input  logic                   key_ready,
  output logic [ROW_W+COL_W-1:0] key_code,
  output logic [7:0]             key_char
);

  import keyscan_pkg::*;

  localparam int CODE_W = ROW_W + COL_W;

  scan_state_t      state_q, state_d;
  logic [CODE_W-1:0] code;
  logic              settle_end;
  logic              run, bump;
  logic              tmr_clr, tmr_en, tmr_done;

  keyscan_stepper #(.CODE_W(CODE_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_step (
    .clk(clk), .rst_n(rst_n), .run(run), .bump(bump),
    .code(code), .settle_end(settle_end)
  );

  keyscan_timer #(.CYCLES(DEBOUNCE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .done(tmr_done)
  );

  keyscan_charmap #(.CODE_W(CODE_W)) u_map (
    .idx(code), .ch(key_char)
  );

  always_comb begin
    state_d = state_q;
    run     = 1'b0;
    bump    = 1'b0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    unique case (state_q)
      ST_SCAN: begin
        run     = 1'b1;
        tmr_clr = 1'b1;
        if (settle_end) begin
          if (!sense_n) state_d = ST_CHECK;
          else          bump    = 1'b1;
        end
      end
      ST_CHECK: begin
        tmr_en = 1'b1;
        if (tmr_done) begin
          if (!sense_n) begin
            state_d = ST_OFFER;
          end else begin
            state_d = ST_SCAN;
            bump    = 1'b1;
          end
        end
      end
      ST_OFFER: begin
        tmr_clr = 1'b1;
        if (key_ready) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        tmr_clr = !sense_n;
        tmr_en  = sense_n;
        if (sense_n && tmr_done) begin
          state_d = ST_SCAN;
          bump    = 1'b1;
        end
      end
      default: state_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_SCAN;
    else        state_q <= state_d;
  end

  assign row_sel   = code[CODE_W-1:COL_W];
  assign col_sel   = code[COL_W-1:0];
  assign key_code  = code;
  assign key_valid = (state_q == ST_OFFER);

endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ROW_W-1:0]       row_sel,
  input logic [COL_W-1:0]       col_sel,
  input logic                   key_valid,
  input logic                   key_ready,
  input logic [ROW_W+COL_W-1:0] key_code,
  input logic [7:0]             key_char
);

  localparam int CW = ROW_W + COL_W;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({row_sel, col_sel}) |-> ({row_sel, col_sel} == CW'($past({row_sel, col_sel}) + 1'b1))); // R2

  AST_SEL_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> ({row_sel, col_sel} == key_code)); // R5

  AST_DIGIT_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_code < 10) |-> (key_char == 8'(8'h30 + key_code))); // R6

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> (key_valid && $stable(key_code) && $stable(key_char))); // R7

  AST_DROP_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |=> !key_valid); // R7

  AST_FREEZE_AFTER_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> $stable({row_sel, col_sel})); // R8

endmodule

bind keypad_scanner keypad_scanner_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .col_sel(col_sel),
  .key_valid(key_valid), .key_ready(key_ready),
  .key_code(key_code), .key_char(key_char)
);

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 2;
  localparam int DEB = 20;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] row_sel, col_sel;
  logic       sense_n;
  logic       key_valid;
  logic       key_ready = 1'b1;
  logic [5:0] key_code;
  logic [7:0] key_char;

  logic       key_down = 1'b0;
  logic [5:0] key_pos = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sense_n = !(key_down && ({row_sel, col_sel} == key_pos));

  keypad_scanner #(.SETTLE_CYCLES(SETTLE), .DEBOUNCE_CYCLES(DEB)) u_keypad_scanner (
    .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .col_sel(col_sel),
    .sense_n(sense_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .key_char(key_char)
  );

  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] want_char(input int k);
    if (k < 10) return 8'(48 + k);
    if (k < 36) return 8'(65 + k - 10);
    if (k < 62) return 8'(97 + k - 36);
    if (k == 62) return 8'h2A;
    return 8'h23;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({row_sel, col_sel} == 6'd0, "R1 select in reset", {row_sel, col_sel}, 0);
    check(key_valid == 1'b0, "R1 valid in reset", key_valid, 0);
    rst_n = 1'b1;
  endtask

  // Idle scan: code after k edges is (k/SETTLE) mod 64, including wrap
  task automatic t_scan_order();
    int first_bad = -1;
    int act = 0, exp = 0;
    for (int k = 1; k <= 140; k++) begin
      @(negedge clk);
      if (first_bad < 0 && {row_sel, col_sel} != 6'((k / SETTLE) % 64)) begin
        first_bad = k; act = {row_sel, col_sel}; exp = (k / SETTLE) % 64;
      end
    end
    check(first_bad < 0, "R2 scan order and wrap", act, exp);
  endtask

  // Full press: report, hold without repeat, release and resume at next code
  task automatic t_press(input int k, input bit slow_ready);
    bit got = 0;
    int extra = 0;
    key_pos = 6'(k);
    key_ready = !slow_ready;
    key_down = 1'b1;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (key_valid) got = 1;
    end
    check(got, "R5 press reported", got, 1);
    check(key_code == 6'(k), "R5 key code", key_code, k);
    check({row_sel, col_sel} == 6'(k), "R3 select frozen on key", {row_sel, col_sel}, k);
    check(key_char == want_char(k), "R6 character", key_char, want_char(k));
    if (slow_ready) begin
      repeat (5) @(negedge clk);
      check(key_valid && key_code == 6'(k) && key_char == want_char(k),
            "R7 held under back-pressure", key_valid, 1);
      key_ready = 1'b1;
      @(negedge clk);
      check(!key_valid, "R7 valid drops after transfer", key_valid, 0);
    end
    for (int i = 0; i < 4 * DEB; i++) begin
      @(negedge clk);
      if (key_valid) extra++;
    end
    check(extra == 0, "R8 no repeat while held", extra, 0);
    check({row_sel, col_sel} == 6'(k), "R8 select held while key down", {row_sel, col_sel}, k);
    key_down = 1'b0;
    repeat (DEB - 1) @(negedge clk);
    check({row_sel, col_sel} == 6'(k), "R8 still frozen before window ends", {row_sel, col_sel}, k);
    @(negedge clk);
    check({row_sel, col_sel} == 6'((k + 1) % 64), "R8 resume at next code",
          {row_sel, col_sel}, (k + 1) % 64);
  endtask

  // Switch opens inside the check window: no report, scan moves on
  task automatic t_short_glitch(input int k);
    int seen = 0;
    bit arrived = 0;
    key_pos = 6'(k);
    key_down = 1'b1;
    for (int i = 0; i < 400 && !arrived; i++) begin
      @(negedge clk);
      if ({row_sel, col_sel} == 6'(k)) arrived = 1;
    end
    repeat (SETTLE + 2) @(negedge clk);
    check({row_sel, col_sel} == 6'(k), "R3 scan stopped on closed key", {row_sel, col_sel}, k);
    key_down = 1'b0;
    for (int i = 0; i < 3 * DEB; i++) begin
      @(negedge clk);
      if (key_valid) seen++;
    end
    check(seen == 0, "R4 glitch not reported", seen, 0);
    check({row_sel, col_sel} != 6'(k), "R4 scanning resumed", {row_sel, col_sel}, (k + 1) % 64);
  endtask

  // Bounce during the release window restarts the window
  task automatic t_release_bounce(input int k);
    bit got = 0;
    int seen = 0;
    key_pos = 6'(k);
    key_down = 1'b1;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (key_valid) got = 1;
    end
    check(got && key_char == want_char(k), "R5 bounce key reported", key_char, want_char(k));
    key_down = 1'b0;
    repeat (DEB / 2) @(negedge clk);
    key_down = 1'b1;
    repeat (2) @(negedge clk);
    key_down = 1'b0;
    for (int i = 0; i < DEB - 1; i++) begin
      @(negedge clk);
      if (key_valid) seen++;
    end
    check({row_sel, col_sel} == 6'(k), "R8 bounce restarts release window", {row_sel, col_sel}, k);
    check(seen == 0, "R8 bounce not reported", seen, 0);
    @(negedge clk);
    check({row_sel, col_sel} == 6'((k + 1) % 64), "R8 resume after clean release",
          {row_sel, col_sel}, (k + 1) % 64);
  endtask

  initial begin
    t_reset();
    t_scan_order();
    t_press(5, 1'b0);
    t_press(10, 1'b0);
    t_press(40, 1'b1);
    t_press(62, 1'b0);
    t_press(63, 1'b0);
    t_press(0, 1'b0);
    t_short_glitch(20);
    t_release_bounce(33);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule